// File: doc/BRIEF.md
# Packet-Addressed OTP Read Controller

This block gives software read access to a one-time-programmable word array whose contents are laid out as consecutive packets. Each packet is one header word followed by a payload. Bits 15:8 of the header hold a size field N, and the payload that follows is N+1 words long. A header whose size field is zero ends the populated region. Software cannot read an arbitrary word. It names a word address, and the controller returns the whole packet whose span covers that address.

To read, software writes the word address into the upper half of a mode register and then writes a control word with bit 6 set. The controller walks the headers starting at word 0 until it reaches the packet that covers the requested address. It then copies that packet's payload into a shadow buffer. A busy flag is high for the whole walk and copy. When the copy ends, the header register shows the packet header and the shadow buffer becomes the visible one. Software then reads the payload through a data register whose word index it can set, and which steps forward by one on every read.

The array is an external synchronous ROM with a one-cycle read latency. The register port is a simple 32-bit bus with a byte offset, and its read data is combinational.

Top module: `otp_pkt_reader`

## Requirements
- R1: After reset the status (0x0C), header (0x20), mode (0x04) and payload index (0x08) registers all read zero.
- R2: The mode register at 0x04 reads back the last value written to it. Its bits 31:16 are the word address used by the next fetch.
- R3: A write to control (0x00) with bit 6 set starts a fetch. Status bit 6 reads 1 from the next cycle until the fetch ends, then reads 0. A control write made while a fetch is running has no effect on that fetch.
- R4: A fetch at any address from a packet's header word to its last payload word leaves that packet's header word in the header register (0x20).
- R5: A write to 0x08 sets the payload index, and reading 0x08 returns the index. Each read of 0x24 returns payload word [index] of the fetched packet and then adds one to the index. Payload word 0 is the word directly after the header, and a size field of N means payload words 0..N.
- R6: If the walk reaches a header whose size field is zero before it covers the address, the fetch ends with busy clear, the header register at zero and status bit 1 (fault) set.
- R7: A fetch also ends with the fault outcome of R6 if the requested address is at or beyond ARRAY_WORDS, or if the walk meets a packet that would extend past the last array word.
- R8: While a fetch is running, reads of 0x20 and 0x24 return the contents left by the previous fetch.
- R9: A fetch issues exactly one ROM read per header visited plus one per payload word copied. ROM reads occur only while busy and only at addresses below ARRAY_WORDS.
- R10: A fetch that finds its packet clears the fault bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Register access strobe for this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| romRdEn | output | 1 | ROM read request |
| romAddr | output | $clog2(ARRAY_WORDS) | ROM word address |
| romData | input | 32 | ROM data, valid the cycle after a request |

## Verification
The bench builds the controller with ARRAY_WORDS = 64 and keeps the default 256-word payload buffers. With a 64-word array, a short packet chain can be laid out so that one bench exercises several outcomes: an exact end-of-array address limit, a terminator header and a packet that overruns the array. The bench rewrites its ROM model between scenarios to produce each of them. Counting ROM requests against a known chain of three packets checks the walk cost. Reads made during a fetch show that the old buffer stays visible until the new packet is complete.

// File: rtl/otp_pkt_pkg.sv
package otp_pkt_pkg;
  localparam int HDR_SIZE_W   = 8;
  localparam int HDR_SIZE_LSB = 8;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_MODE   = 8'h04;
  localparam logic [7:0] OFF_PIDX   = 8'h08;
  localparam logic [7:0] OFF_STATUS = 8'h0C;
  localparam logic [7:0] OFF_HDR    = 8'h20;
  localparam logic [7:0] OFF_DATA   = 8'h24;

  localparam int START_BIT = 6;
  localparam int BUSY_BIT  = 6;
  localparam int FAULT_BIT = 1;

  typedef enum logic [1:0] {
    S_IDLE,
    S_HDR_REQ,
    S_HDR_WAIT,
    S_PAY
  } walkState_t;

  typedef struct packed {
    logic                  busy;
    logic                  hdrLoad;
    logic                  payWrite;
    logic [HDR_SIZE_W-1:0] payIdx;
    logic                  finishOk;
    logic                  finishErr;
  } ctrlStrobes_t;
endpackage

// File: rtl/otp_pkt_ctrl.sv
module otp_pkt_ctrl
  import otp_pkt_pkg::*;
#(
  parameter int ARRAY_WORDS = 2816,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [15:0]       reqAddr,
  input  logic [31:0]       romData,
  output logic              romRdEn,
  output logic [ADDR_W-1:0] romAddr,
  output ctrlStrobes_t      strobes
);
  localparam int CUR_W = 18;
  localparam logic [CUR_W-1:0] ARRAY_END = CUR_W'(ARRAY_WORDS);

  walkState_t            state;
  logic [CUR_W-1:0]      target;
  logic [CUR_W-1:0]      cursor;
  logic [CUR_W-1:0]      pktBase;
  logic [HDR_SIZE_W-1:0] sizeReg;
  logic [HDR_SIZE_W-1:0] issueIdx;
  logic                  issuing;
  logic                  wrPend;
  logic [HDR_SIZE_W-1:0] wrIdx;

  logic [HDR_SIZE_W-1:0] hdrSize;
  logic [CUR_W-1:0]      nextPos;
  logic [CUR_W-1:0]      payAddr;
  logic                  errNow;
  logic                  found;
  logic                  lastWr;

  assign hdrSize = romData[HDR_SIZE_LSB +: HDR_SIZE_W];
  assign nextPos = cursor + CUR_W'(hdrSize) + CUR_W'(2);
  assign payAddr = pktBase + CUR_W'(1) + CUR_W'(issueIdx);
  assign lastWr  = wrPend && (wrIdx == sizeReg);

  always_comb begin
    errNow = 1'b0;
    if (state == S_HDR_REQ)
      errNow = (target >= ARRAY_END) || (cursor >= ARRAY_END);
    else if (state == S_HDR_WAIT)
      errNow = (hdrSize == '0) || (nextPos > ARRAY_END);
  end

  assign found = (state == S_HDR_WAIT) && !errNow && (target < nextPos);

  always_comb begin
    romRdEn = 1'b0;
    romAddr = cursor[ADDR_W-1:0];
    if (state == S_HDR_REQ && !errNow) begin
      romRdEn = 1'b1;
    end else if (state == S_PAY && issuing) begin
      romRdEn = 1'b1;
      romAddr = payAddr[ADDR_W-1:0];
    end
  end

  always_comb begin
    strobes.busy      = (state != S_IDLE);
    strobes.hdrLoad   = found;
    strobes.payWrite  = wrPend;
    strobes.payIdx    = wrIdx;
    strobes.finishOk  = lastWr;
    strobes.finishErr = errNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      target   <= '0;
      cursor   <= '0;
      pktBase  <= '0;
      sizeReg  <= '0;
      issueIdx <= '0;
      issuing  <= 1'b0;
      wrPend   <= 1'b0;
      wrIdx    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (startReq) begin
            target <= CUR_W'(reqAddr);
            cursor <= '0;
            state  <= S_HDR_REQ;
          end
        end
        S_HDR_REQ: begin
          if (errNow) state <= S_IDLE;
          else        state <= S_HDR_WAIT;
        end
        S_HDR_WAIT: begin
          if (errNow) begin
            state <= S_IDLE;
          end else if (found) begin
            pktBase  <= cursor;
            sizeReg  <= hdrSize;
            issueIdx <= '0;
            issuing  <= 1'b1;
            wrPend   <= 1'b0;
            state    <= S_PAY;
          end else begin
            cursor <= nextPos;
            state  <= S_HDR_REQ;
          end
        end
        S_PAY: begin
          wrPend <= issuing;
          wrIdx  <= issueIdx;
          if (issuing) begin
            if (issueIdx == sizeReg) issuing <= 1'b0;
            else                     issueIdx <= issueIdx + 1'b1;
          end
          if (lastWr) begin
            wrPend <= 1'b0;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otp_pkt_dpath.sv
module otp_pkt_dpath
  import otp_pkt_pkg::*;
#(
  parameter int BUF_WORDS = 256
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busEn,
  input  logic         busWe,
  input  logic [7:0]   busAddr,
  input  logic [31:0]  busWdata,
  output logic [31:0]  busRdata,
  input  logic [31:0]  romData,
  input  ctrlStrobes_t strobes,
  output logic         startReq,
  output logic [15:0]  reqAddr,
  output logic [31:0]  hdrValue,
  output logic         faultFlag
);
  localparam int IDX_W = $clog2(BUF_WORDS);

  logic [31:0]      modeReg;
  logic [31:0]      pendHdr;
  logic [IDX_W-1:0] payIdx;
  logic             bankSel;
  logic [1:0][31:0] bankWord;

  logic wrCtrl, wrMode, wrIdx, rdData;

  assign wrCtrl = busEn && busWe && (busAddr == OFF_CTRL);
  assign wrMode = busEn && busWe && (busAddr == OFF_MODE);
  assign wrIdx  = busEn && busWe && (busAddr == OFF_PIDX);
  assign rdData = busEn && !busWe && (busAddr == OFF_DATA);

  assign startReq = wrCtrl && busWdata[START_BIT] && !strobes.busy;
  assign reqAddr  = modeReg[31:16];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [31:0] mem [BUF_WORDS];
    always_ff @(posedge clk) begin
      if (strobes.payWrite && (bankSel != 1'(b)))
        mem[IDX_W'(strobes.payIdx)] <= romData;
    end
    assign bankWord[b] = mem[payIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg   <= '0;
      pendHdr   <= '0;
      payIdx    <= '0;
      bankSel   <= 1'b0;
      hdrValue  <= '0;
      faultFlag <= 1'b0;
    end else begin
      if (wrMode) modeReg <= busWdata;
      if (wrIdx)       payIdx <= busWdata[IDX_W-1:0];
      else if (rdData) payIdx <= payIdx + 1'b1;
      if (strobes.hdrLoad) pendHdr <= romData;
      if (strobes.finishOk) begin
        hdrValue  <= pendHdr;
        faultFlag <= 1'b0;
        bankSel   <= ~bankSel;
      end else if (strobes.finishErr) begin
        hdrValue  <= '0;
        faultFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busEn && !busWe) begin
      case (busAddr)
        OFF_MODE:   busRdata = modeReg;
        OFF_PIDX:   busRdata = 32'(payIdx);
        OFF_STATUS: begin
          busRdata[BUSY_BIT]  = strobes.busy;
          busRdata[FAULT_BIT] = faultFlag;
        end
        OFF_HDR:    busRdata = hdrValue;
        OFF_DATA:   busRdata = bankWord[bankSel];
        default:    busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/otp_pkt_reader.sv
module otp_pkt_reader
  import otp_pkt_pkg::*;
#(
  parameter int ARRAY_WORDS = 2816,
  localparam int ADDR_W     = $clog2(ARRAY_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              romRdEn,
  output logic [ADDR_W-1:0] romAddr,
  input  logic [31:0]       romData
);
  localparam int BUF_WORDS = 2 ** HDR_SIZE_W;

  ctrlStrobes_t strobes;
  logic         startReq;
  logic [15:0]  reqAddr;
  logic [31:0]  hdrValue;
  logic         faultFlag;
  logic         busy;

  assign busy = strobes.busy;

  otp_pkt_ctrl #(
    .ARRAY_WORDS(ARRAY_WORDS),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .reqAddr (reqAddr),
    .romData (romData),
    .romRdEn (romRdEn),
    .romAddr (romAddr),
    .strobes (strobes)
  );

  otp_pkt_dpath #(
    .BUF_WORDS(BUF_WORDS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .busEn    (busEn),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .romData  (romData),
    .strobes  (strobes),
    .startReq (startReq),
    .reqAddr  (reqAddr),
    .hdrValue (hdrValue),
    .faultFlag(faultFlag)
  );
endmodule

// File: rtl/otp_pkt_reader_chk.sv
module otp_pkt_reader_chk #(
  parameter int ARRAY_WORDS = 2816,
  parameter int ADDR_W      = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              busy,
  input logic              romRdEn,
  input logic [ADDR_W-1:0] romAddr,
  input logic [31:0]       hdrValue,
  input logic              faultFlag
);
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> busy);

  assert_rom_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    romRdEn |-> (32'(romAddr) < ARRAY_WORDS));

  assert_rom_only_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    romRdEn |-> busy);

  assert_hdr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(hdrValue));

  assert_fault_hdr_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && faultFlag) |-> (hdrValue == 32'h0));
endmodule

bind otp_pkt_reader otp_pkt_reader_chk #(
  .ARRAY_WORDS(ARRAY_WORDS),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .busy     (busy),
  .romRdEn  (romRdEn),
  .romAddr  (romAddr),
  .hdrValue (hdrValue),
  .faultFlag(faultFlag)
);

// File: tb/otp_pkt_reader_test.sv
`timescale 1ns/1ps
module otp_pkt_reader_test;
  localparam int AW = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        romRdEn;
  logic [5:0]  romAddr;
  logic [31:0] romData;

  logic [31:0] rom [AW];
  int checks = 0;
  int failures = 0;
  int romReads = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (romRdEn) begin
      romData  <= rom[romAddr];
      romReads <= romReads + 1;
    end
  end

  otp_pkt_reader #(.ARRAY_WORDS(AW)) uut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .romRdEn(romRdEn),
    .romAddr(romAddr), .romData(romData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(8'h0C, s);
      if (!s[6]) break;
    end
  endtask

  task automatic fetch(input int addr);
    wr(8'h04, {16'(addr), 16'h0});
    romReads = 0;
    wr(8'h00, 32'h40);
    waitIdle();
  endtask

  function automatic logic [31:0] payPat(input int i);
    return 32'h5000_0000 | (i * 257);
  endfunction

  task automatic loadRom();
    for (int i = 0; i < AW; i++) rom[i] = payPat(i);
    rom[0]  = 32'hB0A0_0200;
    rom[4]  = 32'hB0A1_0401;
    rom[10] = 32'hB0A2_0102;
    rom[13] = 32'h0000_0000;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h0C, v); chk("R1 status", v, 32'h0);
    rd(8'h20, v); chk("R1 header", v, 32'h0);
    rd(8'h04, v); chk("R1 mode", v, 32'h0);
    rd(8'h08, v); chk("R1 index", v, 32'h0);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    wr(8'h04, 32'h1234_ABCD);
    rd(8'h04, v); chk("R2 mode readback", v, 32'h1234_ABCD);
  endtask

  task automatic t_span();
    logic [31:0] v;
    fetch(0);  rd(8'h20, v); chk("R4 addr0", v, rom[0]);
    fetch(3);  rd(8'h20, v); chk("R4 addr3 last of pkt0", v, rom[0]);
    fetch(4);  rd(8'h20, v); chk("R4 addr4 hdr of pkt1", v, rom[4]);
    fetch(9);  rd(8'h20, v); chk("R4 addr9 last of pkt1", v, rom[4]);
    fetch(12); rd(8'h20, v); chk("R4 addr12", v, rom[10]);
    rd(8'h0C, v); chk("R3 busy clear after fetch", v, 32'h0);
  endtask

  task automatic t_payload();
    logic [31:0] v;
    fetch(6);
    wr(8'h08, 32'h0);
    for (int k = 0; k < 5; k++) begin
      rd(8'h24, v); chk("R5 payload sequence", v, rom[5 + k]);
    end
    rd(8'h08, v); chk("R5 index after reads", v, 32'd5);
    wr(8'h08, 32'd2);
    rd(8'h24, v); chk("R5 set index", v, rom[7]);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(8'h04, {16'd1, 16'h0});
    wr(8'h00, 32'h40);
    rd(8'h0C, v); chk("R3 busy after start", v & 32'h40, 32'h40);
    wr(8'h04, {16'd11, 16'h0});
    wr(8'h00, 32'h40);
    waitIdle();
    rd(8'h20, v); chk("R3 second start ignored", v, rom[0]);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    fetch(5);
    wr(8'h08, 32'h0);
    wr(8'h04, {16'd11, 16'h0});
    wr(8'h00, 32'h40);
    rd(8'h20, v); chk("R8 header held", v, rom[4]);
    rd(8'h24, v); chk("R8 data held", v, rom[5]);
    rd(8'h0C, v); chk("R8 still busy", v & 32'h40, 32'h40);
    waitIdle();
    rd(8'h20, v); chk("R8 new header", v, rom[10]);
    wr(8'h08, 32'h1);
    rd(8'h24, v); chk("R8 new data", v, rom[12]);
  endtask

  task automatic t_romcount();
    logic [31:0] v;
    fetch(12); v = 32'(romReads); chk("R9 rom reads addr12", v, 32'd5);
    fetch(2);  v = 32'(romReads); chk("R9 rom reads addr2", v, 32'd4);
    fetch(13); v = 32'(romReads); chk("R9 rom reads terminator", v, 32'd4);
  endtask

  task automatic t_term();
    logic [31:0] v;
    fetch(13);
    rd(8'h0C, v); chk("R6 fault status", v, 32'h2);
    rd(8'h20, v); chk("R6 header zero", v, 32'h0);
    fetch(0);
    rd(8'h0C, v); chk("R10 fault cleared", v, 32'h0);
    rd(8'h20, v); chk("R10 header", v, rom[0]);
  endtask

  task automatic t_end();
    logic [31:0] v;
    fetch(70);
    rd(8'h0C, v); chk("R7 addr past array", v, 32'h2);
    fetch(63);
    rd(8'h0C, v); chk("R7 addr 63 on terminator", v, 32'h2);
    rom[13] = 32'hB0A3_3C03;
    fetch(20);
    rd(8'h0C, v); chk("R7 overrun packet", v, 32'h2);
    rd(8'h20, v); chk("R7 header zero", v, 32'h0);
    rom[13] = 32'h0;
    fetch(10);
    rd(8'h20, v); chk("R10 after overrun", v, rom[10]);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    loadRom();
    romData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_mode();
    t_span();
    t_payload();
    t_busy();
    t_hold();
    t_romcount();
    t_term();
    t_end();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule